// File: doc/BRIEF.md
# Serial Transceiver with Request/Clear Flow Control

This block is an asynchronous serial transmitter and receiver. Each side has its own 16-entry FIFO. A free-running divider makes a tick at sixteen times the bit rate. Both serial engines count bit periods on that tick. The transmitter takes bytes from its FIFO and sends each one as a frame on `txd`. A frame is one low start bit, eight data bits with the least-significant bit first, and one high stop bit. The receiver finds the falling edge of a start bit on `rxd`, samples every bit at mid-period, and stores each byte in its FIFO. A flag bit that marks a bad stop bit travels with the byte.

Two active-low pins carry handshaking with the link partner, and each direction has its own enable. When the clear-to-send check is enabled, the transmitter starts a new character only while `cts_n` is low. It samples `cts_n` through a two-flop synchroniser, and only while it is idle. A character that has already started always runs to its stop bit. When the request-to-send automation is enabled, the receive FIFO fill level drives `rts_n`, compared against a 4-bit watermark, and the software request bit has no effect. When the automation is disabled, `rts_n` follows the software bit.

The transmitter's states are TX_IDLE, TX_START, TX_DATA and TX_STOP. It moves from TX_IDLE to TX_START when it pops a byte. It moves from TX_START to TX_DATA after one bit period, stays in TX_DATA for eight bit periods, then moves to TX_STOP, and returns to TX_IDLE one bit period later. The receiver's states are RX_IDLE, RX_START, RX_DATA and RX_STOP. A falling edge takes it from RX_IDLE to RX_START. At the middle of the start bit it goes to RX_DATA if the line is still low, or back to RX_IDLE (a false start) if it is not. It moves from RX_DATA to RX_STOP after eight samples, and from RX_STOP to RX_IDLE after the stop-bit sample, at which point it pushes the byte.

Top module: `uart_flowctl`

## Requirements
- R1: While idle, `txd` is high. A frame is one low start bit, eight data bits sent bit 0 first, and one high stop bit, each lasting 16 ticks. A byte of 0x00 holds the line low for 9 bit periods, 0xFE for 2 and 0xFF for 1.
- R2: Every byte value from 0x00 to 0xFF that is sent from `txd` to `rxd` comes out of the receive FIFO unchanged, in order, with `rx_ferr` at 0.
- R3: With the clear-to-send check enabled (`ctrl_data[0]`=1), no start bit begins while `cts_n` is 1. Queued bytes are sent once `cts_n` goes to 0.
- R4: If `cts_n` rises during a character, that character finishes and is received whole, and the next queued byte is held until `cts_n` falls again.
- R5: With `ctrl_data[0]`=0, `cts_n` is ignored, and a queued byte is sent while `cts_n` is 1.
- R6: With the request automation enabled (`ctrl_data[1]`=1), `rts_n` is 0 while `rx_level` is below the watermark `ctrl_data[6:3]` and 1 once `rx_level` is at or above it. A watermark of 0 therefore keeps `rts_n` at 1.
- R7: While `ctrl_data[1]`=1, the software request bit `ctrl_data[2]` has no effect on `rts_n`.
- R8: With `ctrl_data[1]`=0, `rts_n` is the inverse of `ctrl_data[2]`. A value of 1 in that bit drives the pin low.
- R9: A frame whose stop bit is sampled as 0 still stores its byte, and `rx_ferr` reads 1 for that byte. A later good frame reads 0.
- R10: A byte that arrives while the receive FIFO holds 16 entries is dropped, and `overrun` goes to 1 and stays at 1. The 16 stored bytes are unchanged.
- R11: After reset, `txd`=1, `rts_n`=1, `rx_level`=0, `tx_full`=0 and `overrun`=0.
- R12: `tx_full` is 1 once 16 bytes are waiting in the transmit FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_push | input | 1 | Write `tx_byte` into the transmit FIFO |
| tx_byte | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit FIFO holds 16 bytes |
| ctrl_wr | input | 1 | Load the control register from `ctrl_data` |
| ctrl_data | input | 7 | [0] CTS check enable, [1] RTS automation enable, [2] software request, [6:3] watermark |
| rd_en | input | 1 | Pop the head of the receive FIFO |
| rx_data | output | 8 | Byte at the head of the receive FIFO |
| rx_ferr | output | 1 | Stop-bit error flag of the head byte |
| rx_level | output | 5 | Receive FIFO fill level, 0 to 16 |
| overrun | output | 1 | Sticky flag: a received byte was dropped |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rts_n | output | 1 | Request to send, active low |
| cts_n | input | 1 | Clear to send, active low |

## Verification
The data path is swept over all 256 byte values in a loop from `txd` to `rxd`. Independently, the length of the low run on `txd` is measured for 0x00, 0xFE and 0xFF. These runs tell a bit-order or bit-period fault apart from a stop-bit fault. Flow control is tried with `cts_n` held high from before the first byte is queued, with `cts_n` raised partway through a character, and with the check disabled. Together these separate gating at the character boundary from aborting a character or ignoring the pin altogether. The request pin is swept over every watermark at every fill level from 16 down to 0, with the software bit toggling throughout. Hand-built frames with a bad stop bit, and a seventeenth frame into a full FIFO, cover the error paths.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    localparam int MARK_W = 4;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Control word: first field is the most significant.
    typedef struct packed {
        logic [MARK_W-1:0] mark;
        logic              sw_req;
        logic              rts_auto;
        logic              cts_gate;
    } ctrl_t;

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [WIDTH-1:0]           din,
    input  logic                       rd,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic             full;
    logic             empty;
    logic             wr_ok;
    logic             rd_ok;

    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign dout  = mem[rptr];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_ok) begin
                wptr <= wptr + 1'b1;
            end
            if (rd_ok) begin
                rptr <= rptr + 1'b1;
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R10: a write into a full FIFO without a read leaves it full.
    p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd) |=> (level == LW'(DEPTH)));

endmodule

// File: rtl/ufc_tx.sv
module ufc_tx
    import ufc_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cts_gate,
    input  logic              cts_n,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              txd
);
    localparam int OW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);
    localparam logic [OW-1:0] OS_LAST  = OW'(OVS - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

    tx_state_e         state;
    logic [OW-1:0]     os;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;
    logic              cts_meta;
    logic              cts_sync;
    logic              bit_end;
    logic              go;

    assign bit_end = tick && (os == OS_LAST);
    assign go      = !fifo_empty && (!cts_gate || !cts_sync);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            os       <= '0;
            bitn     <= '0;
            shreg    <= '0;
            cts_meta <= 1'b1;
            cts_sync <= 1'b1;
        end else begin
            cts_meta <= cts_n;
            cts_sync <= cts_meta;
            if (state != TX_IDLE && tick) begin
                os <= bit_end ? '0 : os + 1'b1;
            end
            unique case (state)
                TX_IDLE: begin
                    if (fifo_pop) begin
                        shreg <= fifo_data;
                        os    <= '0;
                        state <= TX_START;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        bitn  <= '0;
                        state <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        shreg <= shreg >> 1;
                        if (bitn == BIT_LAST) begin
                            state <= TX_STOP;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        state <= TX_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        fifo_pop = 1'b0;
        txd      = 1'b1;
        unique case (state)
            TX_IDLE:  fifo_pop = go;
            TX_START: txd      = 1'b0;
            TX_DATA:  txd      = shreg[0];
            TX_STOP:  txd      = 1'b1;
        endcase
    end

    // R3: while gated and the synchronised pin is high, no character starts.
    p_cts_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && cts_gate && cts_sync) |=> (state == TX_IDLE));

    // R4: a character in its data bits is never abandoned.
    p_no_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DATA) |=> (state == TX_DATA || state == TX_STOP));

    // R1: the stop bit always leads back to idle.
    p_stop_to_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP && bit_end) |=> (state == TX_IDLE));

endmodule

// File: rtl/ufc_rx.sv
module ufc_rx
    import ufc_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              push,
    output logic [DATA_W:0]   push_data
);
    localparam int OW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);
    localparam logic [OW-1:0] OS_LAST  = OW'(OVS - 1);
    localparam logic [OW-1:0] OS_MID   = OW'(OVS / 2 - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

    rx_state_e         state;
    logic [OW-1:0]     os;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;
    logic              rx_meta;
    logic              rx_sync;
    logic              rx_prev;
    logic              bit_end;
    logic              fall;

    assign bit_end = tick && (os == OS_LAST);
    assign fall    = rx_prev && !rx_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            os      <= '0;
            bitn    <= '0;
            shreg   <= '0;
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
            rx_prev <= 1'b1;
        end else begin
            rx_meta <= rxd;
            rx_sync <= rx_meta;
            rx_prev <= rx_sync;
            unique case (state)
                RX_IDLE: begin
                    if (fall) begin
                        os    <= '0;
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (os == OS_MID) begin
                            os   <= '0;
                            bitn <= '0;
                            state <= rx_sync ? RX_IDLE : RX_DATA;
                        end else begin
                            os <= os + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        os <= bit_end ? '0 : os + 1'b1;
                    end
                    if (bit_end) begin
                        shreg <= {rx_sync, shreg[DATA_W-1:1]};
                        if (bitn == BIT_LAST) begin
                            state <= RX_STOP;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        os <= bit_end ? '0 : os + 1'b1;
                    end
                    if (bit_end) begin
                        state <= RX_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        push      = 1'b0;
        push_data = {!rx_sync, shreg};
        unique case (state)
            RX_IDLE, RX_START, RX_DATA: push = 1'b0;
            RX_STOP:                    push = bit_end;
        endcase
    end

    // R2: data bits are followed only by more data bits or the stop bit.
    p_data_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA) |=> (state == RX_DATA || state == RX_STOP));

    // R9: a stored byte, good or bad stop bit, returns the receiver to idle.
    p_push_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (state == RX_IDLE));

endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
    import ufc_pkg::*;
#(
    parameter int CLK_DIV = 27,
    parameter int OVS     = 16,
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_push,
    input  logic [DATA_W-1:0]       tx_byte,
    output logic                    tx_full,
    input  logic                    ctrl_wr,
    input  logic [MARK_W+2:0]       ctrl_data,
    input  logic                    rd_en,
    output logic [DATA_W-1:0]       rx_data,
    output logic                    rx_ferr,
    output logic [$clog2(DEPTH):0]  rx_level,
    output logic                    overrun,
    output logic                    txd,
    input  logic                    rxd,
    output logic                    rts_n,
    input  logic                    cts_n
);
    localparam int LW = $clog2(DEPTH) + 1;

    ctrl_t             ctrl;
    logic              tick;
    logic [LW-1:0]     tx_level;
    logic [DATA_W-1:0] tx_head;
    logic              tx_pop;
    logic              rx_push;
    logic [DATA_W:0]   rx_word;
    logic [DATA_W:0]   rx_head;
    logic              rx_full;

    generate
        if (CLK_DIV <= 1) begin : g_tick_every
            assign tick = 1'b1;
        end else begin : g_tick_div
            localparam int DCW = $clog2(CLK_DIV);
            logic [DCW-1:0] dcnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dcnt <= '0;
                end else if (dcnt == DCW'(CLK_DIV - 1)) begin
                    dcnt <= '0;
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end
            assign tick = (dcnt == DCW'(CLK_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            overrun <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl <= ctrl_t'(ctrl_data);
            end
            if (rx_push && rx_full) begin
                overrun <= 1'b1;
            end
        end
    end

    ufc_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (tx_push),
        .din   (tx_byte),
        .rd    (tx_pop),
        .dout  (tx_head),
        .level (tx_level)
    );

    ufc_tx #(.OVS(OVS), .DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cts_gate   (ctrl.cts_gate),
        .cts_n      (cts_n),
        .fifo_empty (tx_level == '0),
        .fifo_data  (tx_head),
        .fifo_pop   (tx_pop),
        .txd        (txd)
    );

    ufc_rx #(.OVS(OVS), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rxd       (rxd),
        .push      (rx_push),
        .push_data (rx_word)
    );

    ufc_fifo #(.WIDTH(DATA_W + 1), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (rx_push),
        .din   (rx_word),
        .rd    (rd_en),
        .dout  (rx_head),
        .level (rx_level)
    );

    always_comb begin
        tx_full = (tx_level == LW'(DEPTH));
        rx_full = (rx_level == LW'(DEPTH));
        rx_data = rx_head[DATA_W-1:0];
        rx_ferr = rx_head[DATA_W];
        if (ctrl.rts_auto) begin
            rts_n = (rx_level >= LW'(ctrl.mark));
        end else begin
            rts_n = !ctrl.sw_req;
        end
    end

    // R7: under automation, with level and watermark steady, the pin is steady
    // whatever the software request bit does.
    p_rts_sw_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.rts_auto && $past(ctrl.rts_auto) && $stable(ctrl.mark) && $stable(rx_level))
        |-> $stable(rts_n));

    // R10: the overrun flag never clears on its own.
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: tb/uart_flowctl_bench.sv
`timescale 1ns/1ps
module uart_flowctl_bench;
    localparam int DIV   = 1;
    localparam int BITC  = 16 * DIV;
    localparam int HALF  = BITC / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_push = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_full;
    logic       ctrl_wr = 1'b0;
    logic [6:0] ctrl_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ferr;
    logic [4:0] rx_level;
    logic       overrun;
    logic       txd;
    logic       rxd;
    logic       rts_n;
    logic       cts_n = 1'b1;
    logic       loop_sel = 1'b1;
    logic       bench_rxd = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] mon_byte [$];
    bit         mon_ok   [$];

    assign rxd = loop_sel ? txd : bench_rxd;

    always #2.5 clk = ~clk;

    uart_flowctl #(.CLK_DIV(DIV)) u_uart_flowctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_push   (tx_push),
        .tx_byte   (tx_byte),
        .tx_full   (tx_full),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (ctrl_data),
        .rd_en     (rd_en),
        .rx_data   (rx_data),
        .rx_ferr   (rx_ferr),
        .rx_level  (rx_level),
        .overrun   (overrun),
        .txd       (txd),
        .rxd       (rxd),
        .rts_n     (rts_n),
        .cts_n     (cts_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [3:0] mark, input logic sw, input logic rts_on, input logic cts_on);
        @(negedge clk);
        ctrl_wr   = 1'b1;
        ctrl_data = {mark, sw, rts_on, cts_on};
        @(negedge clk);
        ctrl_wr   = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        while (tx_full) @(negedge clk);
        tx_push = 1'b1;
        tx_byte = b;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] d, output logic fe);
        @(negedge clk);
        d     = rx_data;
        fe    = rx_ferr;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_level(input int n, input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (rx_level == 5'(n)) break;
        end
    endtask

    task automatic send_raw(input logic [7:0] b, input logic stopb);
        @(negedge clk);
        bench_rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            bench_rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        bench_rxd = stopb;
        repeat (BITC) @(negedge clk);
        bench_rxd = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic low_run(input logic [7:0] b, input int exp_len, input string req);
        int cnt;
        logic [7:0] d;
        logic fe;
        push_tx(b);
        for (int i = 0; i < 50 && txd !== 1'b0; i++) @(negedge clk);
        cnt = 0;
        while (txd === 1'b0 && cnt < 400) begin
            cnt++;
            @(negedge clk);
        end
        chk(req, cnt, exp_len);
        wait_level(1, 300);
        pop_rx(d, fe);
        chk(req, d, b);
    endtask

    // Independent line decoder on txd.
    initial begin
        logic [7:0] b;
        logic st;
        logic sp;
        forever begin
            @(negedge txd);
            repeat (HALF) @(posedge clk);
            #1 st = txd;
            for (int i = 0; i < 8; i++) begin
                repeat (BITC) @(posedge clk);
                #1 b[i] = txd;
            end
            repeat (BITC) @(posedge clk);
            #1 sp = txd;
            mon_byte.push_back(b);
            mon_ok.push_back(st == 1'b0 && sp == 1'b1);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic fe;
        int cnt;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 txd", txd, 1);
        chk("R11 rts_n", rts_n, 1);
        chk("R11 rx_level", rx_level, 0);
        chk("R11 tx_full", tx_full, 0);
        chk("R11 overrun", overrun, 0);

        // R1 low-run lengths: start bit plus leading zero data bits
        loop_sel = 1'b1;
        low_run(8'h00, 9 * BITC, "R1 run00");
        low_run(8'hFE, 2 * BITC, "R1 runFE");
        low_run(8'hFF, 1 * BITC, "R1 runFF");

        // R5: gate disabled, cts_n high, byte still goes out
        cts_n = 1'b1;
        push_tx(8'h6B);
        wait_level(1, 400);
        pop_rx(d, fe);
        chk("R5 data", d, 8'h6B);

        // R2 sweep of all byte values, with R1 frame checks from the decoder
        repeat (40) @(negedge clk);
        mon_byte.delete();
        mon_ok.delete();
        for (int g = 0; g < 32; g++) begin
            for (int k = 0; k < 8; k++) push_tx(8'(g * 8 + k));
            wait_level(8, 3000);
            for (int k = 0; k < 8; k++) begin
                pop_rx(d, fe);
                chk("R2 data", d, 32'(g * 8 + k));
                chk("R2 ferr", fe, 0);
            end
        end
        repeat (20) @(negedge clk);
        chk("R1 frame count", mon_byte.size(), 256);
        for (int i = 0; i < 256 && i < mon_byte.size(); i++) begin
            chk("R1 decoded byte", mon_byte[i], 32'(i));
            chk("R1 start/stop levels", mon_ok[i], 1);
        end

        // R3 and R12: gated and held off, queue fills without sending
        set_ctrl(4'd0, 1'b0, 1'b0, 1'b1);
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 16; k++) push_tx(8'(8'h50 + k));
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) cnt++;
        end
        chk("R3 no start while held", cnt, 0);
        chk("R3 nothing received", rx_level, 0);
        chk("R12 tx_full", tx_full, 1);
        cts_n = 1'b0;
        wait_level(16, 16 * 170 + 200);
        chk("R3 all sent after release", rx_level, 16);
        for (int k = 0; k < 16; k++) begin
            pop_rx(d, fe);
            chk("R3 data", d, 32'(8'h50 + k));
        end

        // R4: cts_n rises mid character
        cts_n = 1'b0;
        push_tx(8'h11);
        push_tx(8'h22);
        for (int i = 0; i < 50 && txd !== 1'b0; i++) @(negedge clk);
        repeat (BITC * 3) @(negedge clk);
        cts_n = 1'b1;
        repeat (BITC * 20) @(negedge clk);
        chk("R4 first completes", rx_level, 1);
        chk("R4 line idle after", txd, 1);
        pop_rx(d, fe);
        chk("R4 first data", d, 8'h11);
        chk("R4 first ferr", fe, 0);
        cts_n = 1'b0;
        wait_level(1, 400);
        pop_rx(d, fe);
        chk("R4 held byte sent later", d, 8'h22);
        set_ctrl(4'd0, 1'b0, 1'b0, 1'b0);

        // R9: bad stop bit then good frame, driven directly
        loop_sel = 1'b0;
        repeat (BITC) @(negedge clk);
        send_raw(8'hC3, 1'b0);
        send_raw(8'h3C, 1'b1);
        wait_level(2, 100);
        pop_rx(d, fe);
        chk("R9 bad frame data", d, 8'hC3);
        chk("R9 bad frame flag", fe, 1);
        pop_rx(d, fe);
        chk("R9 good frame data", d, 8'h3C);
        chk("R9 good frame flag", fe, 0);

        // R10: fill to 16, seventeenth dropped
        for (int k = 0; k < 16; k++) send_raw(8'(8'h80 + k), 1'b1);
        chk("R10 level 16", rx_level, 16);
        chk("R10 no overrun yet", overrun, 0);
        send_raw(8'hEE, 1'b1);
        chk("R10 level stays 16", rx_level, 16);
        chk("R10 overrun set", overrun, 1);

        // R6 and R7: every watermark at every fill level, software bit toggling
        for (int c = 16; c >= 0; c--) begin
            for (int w = 0; w < 16; w++) begin
                set_ctrl(4'(w), 1'(w ^ c), 1'b1, 1'b0);
                chk("R6 R7 rts_n vs watermark", rts_n, (c >= w) ? 1 : 0);
            end
            if (c > 0) begin
                pop_rx(d, fe);
                chk("R10 stored data intact", d, 32'(8'h80 + 16 - c));
            end
        end
        chk("R10 overrun sticky", overrun, 1);

        // R7 explicit: level 0, watermark 5, software bit both ways
        set_ctrl(4'd5, 1'b0, 1'b1, 1'b0);
        chk("R7 sw=0", rts_n, 0);
        set_ctrl(4'd5, 1'b1, 1'b1, 1'b0);
        chk("R7 sw=1", rts_n, 0);

        // R8: automation off, pin follows software bit
        set_ctrl(4'd0, 1'b1, 1'b0, 1'b0);
        chk("R8 sw=1 drives low", rts_n, 0);
        set_ctrl(4'd15, 1'b0, 1'b0, 1'b0);
        chk("R8 sw=0 releases", rts_n, 1);
        set_ctrl(4'd15, 1'b1, 1'b0, 1'b0);
        chk("R8 sw=1 with watermark set", rts_n, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule